// File: doc/BRIEF.md
# Page Write Byte Latch

This block sits between a serial bus slave front end and the programming sequencer of a small non-volatile memory. Once the front end has decoded a word address for a write transaction, the block takes the data bytes that follow, one strobe per byte, into an eight-entry latch. Each entry records the byte and the position it will land on inside its aligned eight-byte block. For each incoming strobe the block says at once whether it accepts it, and the front end turns that answer into the bus acknowledge.

When the transaction closes with STOP, the block decides whether programming goes ahead. One to seven bytes are handed over as byte mode, with linear addresses. Exactly eight bytes are handed over as page mode, where only the low three address bits advance. A ninth byte is refused, and the whole transaction is dropped. A STOP that follows only an address asks for a pointer update and nothing else. A repeated START in the middle of a write abandons it. While a request is outstanding, or while the busy input is high, nothing is accepted. The request clears when the sequencer reports done. The sequencer reads the entries back through an indexed port, which returns each byte's data and its target address.

Top module: `pgw_latch`

## Requirements
- R1: An address strobe is acknowledged whenever busy_i is low and no program request is outstanding. It opens a collection with a byte count of 0 and latches addr_i as the base address.
- R2: While a collection is open and fewer than 8 bytes are held, a data strobe is acknowledged, stored at entry index equal to the count, and the count rises by 1.
- R3: A data strobe that arrives when 8 bytes are already held is not acknowledged, and neither is any later one. The count reads 0 afterwards, and the following STOP gives neither a program request nor a pointer update.
- R4: STOP with 1 to 8 bytes held raises prog_req_o from the next cycle. It stays high until done_i, with prog_cnt_o equal to the byte count.
- R5: page_mode_o is 1 when the count is 8 and 0 for counts 1 to 7.
- R6: rd_data_o returns the byte at entry rd_idx_i. In page mode rd_addr_o is {base[7:3], (base+rd_idx_i) mod 8}. In byte mode it is (base+rd_idx_i) mod 256.
- R7: next_ptr_o equals the base when 8 bytes are held, and (base+count) mod 256 otherwise.
- R8: STOP with an open collection and 0 bytes gives a single-cycle ptr_upd_o pulse in the next cycle and no program request.
- R9: START while a collection is open, or while one is being dropped, abandons it. The count returns to 0 and the next STOP requests nothing.
- R10: While busy_i is high, neither address nor data strobes are acknowledged, and the count does not change.
- R11: While prog_req_o is high, address and data strobes are not acknowledged and START and STOP have no effect. done_i clears prog_req_o and the count in the next cycle.
- R12: After reset, prog_req_o, ptr_upd_o and the count are 0, and with no strobe applied ack_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | START or repeated START seen on the bus |
| stop_i | input | 1 | STOP seen on the bus |
| addr_load_i | input | 1 | Word address byte received |
| addr_i | input | 8 | Word address value |
| byte_vld_i | input | 1 | Data byte received |
| byte_i | input | 8 | Data byte value |
| busy_i | input | 1 | Programming cycle in progress, block captures |
| done_i | input | 1 | Sequencer finished with the latched bytes |
| rd_idx_i | input | 3 | Entry index for the read port |
| ack_o | output | 1 | Current strobe accepted (combinational) |
| prog_req_o | output | 1 | Program request held until done |
| prog_cnt_o | output | 4 | Bytes held |
| page_mode_o | output | 1 | 1 for an eight-byte page, 0 for byte mode |
| base_addr_o | output | 8 | Latched starting word address |
| rd_data_o | output | 8 | Data byte of the selected entry |
| rd_addr_o | output | 8 | Target address of the selected entry |
| next_ptr_o | output | 8 | Word pointer after the held bytes |
| ptr_upd_o | output | 1 | Address-only transaction pulse |

## Verification
The bench builds the block with its default parameters: eight entries, eight-bit data and an eight-bit word address. In that configuration all 256 base addresses can be swept. For each base it runs every byte count from 0 to 10, so block-boundary wrap in page mode, wrap of the full address in byte mode, the exact eighth-byte limit and runs of refused bytes after overflow are all covered. Separate sequences cover an abort by repeated START, strobes blocked by busy, and strobes blocked while a request is outstanding.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_DROP = 2'd2,
    ST_PROG = 2'd3
  } pgw_state_e;
endpackage

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
  import pgw_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             addr_load_i,
  input  logic             byte_vld_i,
  input  logic             busy_i,
  input  logic             done_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             open_o,
  output logic             cap_o,
  output logic             ovf_o,
  output logic             done_o,
  output logic             ack_o,
  output logic             req_o,
  output logic             ptr_upd_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  pgw_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ptr_upd_q;
  logic             can_open, can_cap;

  // Acceptance windows
  always_comb begin
    can_open = !busy_i && (state_q != ST_PROG);
    can_cap  = !busy_i && (state_q == ST_FILL) && (cnt_q < FULL);
  end

  assign open_o = addr_load_i && can_open;
  assign cap_o  = byte_vld_i && can_cap;
  assign ovf_o  = byte_vld_i && !busy_i && (state_q == ST_FILL) && (cnt_q == FULL);
  assign done_o = done_i && (state_q == ST_PROG);
  assign ack_o  = open_o || cap_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      ptr_upd_q <= 1'b0;
    end else begin
      ptr_upd_q <= 1'b0;
      if (state_q == ST_PROG) begin
        if (done_i) begin
          state_q <= ST_IDLE;
          cnt_q   <= '0;
        end
      end else if (start_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else if (stop_i) begin
        if (state_q == ST_FILL && cnt_q != '0) begin
          state_q <= ST_PROG;
        end else begin
          if (state_q == ST_FILL) ptr_upd_q <= 1'b1;
          state_q <= ST_IDLE;
          cnt_q   <= '0;
        end
      end else if (open_o) begin
        state_q <= ST_FILL;
        cnt_q   <= '0;
      end else if (cap_o) begin
        cnt_q <= cnt_q + 1'b1;
      end else if (ovf_o) begin
        state_q <= ST_DROP;
        cnt_q   <= '0;
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign req_o     = (state_q == ST_PROG);
  assign ptr_upd_o = ptr_upd_q;
endmodule

// File: rtl/pgw_store.sv
module pgw_store #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  parameter int OFS_W  = 3,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [CNT_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdat_i,
  input  logic [OFS_W-1:0]  wofs_i,
  input  logic              clr_i,
  input  logic [OFS_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdat_o,
  output logic [OFS_W-1:0]  rofs_o
);
  logic [DEPTH-1:0][DATA_W-1:0] dat_bus;
  logic [DEPTH-1:0][OFS_W-1:0]  ofs_bus;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic [DATA_W-1:0] dat_q;
    logic [OFS_W-1:0]  ofs_q;
    logic              hit;
    assign hit = we_i && (widx_i == CNT_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dat_q <= '0;
        ofs_q <= '0;
      end else if (clr_i) begin
        dat_q <= '0;
        ofs_q <= '0;
      end else if (hit) begin
        dat_q <= wdat_i;
        ofs_q <= wofs_i;
      end
    end
    assign dat_bus[e] = dat_q;
    assign ofs_bus[e] = ofs_q;
  end

  assign rdat_o = dat_bus[ridx_i];
  assign rofs_o = ofs_bus[ridx_i];
endmodule

// File: rtl/pgw_addr.sv
module pgw_addr #(
  parameter int ADDR_W = 8,
  parameter int OFS_W  = 3,
  parameter int CNT_W  = 4
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              page_i,
  input  logic [OFS_W-1:0]  ridx_i,
  input  logic [OFS_W-1:0]  rofs_i,
  output logic [OFS_W-1:0]  wofs_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [ADDR_W-1:0] next_ptr_o
);
  // Address inside the aligned block of the base
  function automatic logic [ADDR_W-1:0] in_block(input logic [ADDR_W-1:0] b,
                                                 input logic [OFS_W-1:0] o);
    return {b[ADDR_W-1:OFS_W], o};
  endfunction

  // Linear step with wrap over the full address width
  function automatic logic [ADDR_W-1:0] lin_step(input logic [ADDR_W-1:0] b,
                                                 input logic [CNT_W-1:0] s);
    return b + ADDR_W'(s);
  endfunction

  function automatic logic [OFS_W-1:0] slot_ofs(input logic [ADDR_W-1:0] b,
                                                input logic [CNT_W-1:0] s);
    return b[OFS_W-1:0] + s[OFS_W-1:0];
  endfunction

  assign wofs_o     = slot_ofs(base_i, cnt_i);
  assign rd_addr_o  = page_i ? in_block(base_i, rofs_i) : lin_step(base_i, CNT_W'(ridx_i));
  assign next_ptr_o = page_i ? in_block(base_i, slot_ofs(base_i, cnt_i))
                             : lin_step(base_i, cnt_i);
endmodule

// File: rtl/pgw_latch.sv
module pgw_latch #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  localparam int OFS_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [OFS_W-1:0]  rd_idx_i,
  output logic              ack_o,
  output logic              prog_req_o,
  output logic [CNT_W-1:0]  prog_cnt_o,
  output logic              page_mode_o,
  output logic [ADDR_W-1:0] base_addr_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [ADDR_W-1:0] next_ptr_o,
  output logic              ptr_upd_o
);
  logic [CNT_W-1:0]  cnt;
  logic              open_evt, cap_evt, ovf_evt, done_evt;
  logic [ADDR_W-1:0] base_q;
  logic [OFS_W-1:0]  wofs, rofs;
  logic              page;

  pgw_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .addr_load_i(addr_load_i), .byte_vld_i(byte_vld_i), .busy_i(busy_i),
    .done_i(done_i), .cnt_o(cnt), .open_o(open_evt), .cap_o(cap_evt),
    .ovf_o(ovf_evt), .done_o(done_evt), .ack_o(ack_o), .req_o(prog_req_o),
    .ptr_upd_o(ptr_upd_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        base_q <= '0;
    else if (open_evt) base_q <= addr_i;
  end

  assign page = (cnt == CNT_W'(DEPTH));

  pgw_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .OFS_W(OFS_W), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we_i(cap_evt), .widx_i(cnt), .wdat_i(byte_i),
    .wofs_i(wofs), .clr_i(done_evt), .ridx_i(rd_idx_i), .rdat_o(rd_data_o),
    .rofs_o(rofs)
  );

  pgw_addr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .CNT_W(CNT_W)) u_addr (
    .base_i(base_q), .cnt_i(cnt), .page_i(page), .ridx_i(rd_idx_i),
    .rofs_i(rofs), .wofs_o(wofs), .rd_addr_o(rd_addr_o), .next_ptr_o(next_ptr_o)
  );

  assign prog_cnt_o  = cnt;
  assign page_mode_o = page;
  assign base_addr_o = base_q;
endmodule

// File: rtl/pgw_latch_chk.sv
module pgw_latch_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             addr_load_i,
  input logic             busy_i,
  input logic             stop_i,
  input logic             done_i,
  input logic             ack_o,
  input logic             prog_req_o,
  input logic [CNT_W-1:0] prog_cnt_o,
  input logic             ptr_upd_o,
  input logic             cap_evt,
  input logic             ovf_evt
);
  a_r1_open_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_load_i && ack_o) |=> (prog_cnt_o == '0 && !prog_req_o));

  a_r2_cap_counts: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (prog_cnt_o == CNT_W'($past(prog_cnt_o) + 1'b1)));

  a_r3_ovf_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |-> !ack_o);

  a_r3_ovf_no_prog: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (!prog_req_o && prog_cnt_o == '0));

  a_r4_req_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_req_o) |-> $past(stop_i));

  a_r4_req_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req_o |-> (prog_cnt_o != '0 && prog_cnt_o <= CNT_W'(DEPTH)));

  a_r8_ptr_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_upd_o |-> !prog_req_o);

  a_r10_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> !ack_o);

  a_r11_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req_o && !done_i) |=> (prog_req_o && $stable(prog_cnt_o)));

  a_r11_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req_o && done_i) |=> (!prog_req_o && prog_cnt_o == '0));

  a_r11_req_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req_o |-> !ack_o);
endmodule

bind pgw_latch pgw_latch_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_load_i(addr_load_i), .busy_i(busy_i),
  .stop_i(stop_i), .done_i(done_i), .ack_o(ack_o), .prog_req_o(prog_req_o),
  .prog_cnt_o(prog_cnt_o), .ptr_upd_o(ptr_upd_o), .cap_evt(cap_evt),
  .ovf_evt(ovf_evt)
);

// File: tb/pgw_latch_tb.sv
`timescale 1ns/1ps
module pgw_latch_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, stop_i = 1'b0, addr_load_i = 1'b0, byte_vld_i = 1'b0;
  logic       busy_i = 1'b0, done_i = 1'b0;
  logic [7:0] addr_i = '0, byte_i = '0;
  logic [2:0] rd_idx_i = '0;
  logic       ack_o, prog_req_o, page_mode_o, ptr_upd_o;
  logic [3:0] prog_cnt_o;
  logic [7:0] base_addr_o, rd_data_o, rd_addr_o, next_ptr_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  pgw_latch u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .addr_load_i(addr_load_i), .addr_i(addr_i), .byte_vld_i(byte_vld_i),
    .byte_i(byte_i), .busy_i(busy_i), .done_i(done_i), .rd_idx_i(rd_idx_i),
    .ack_o(ack_o), .prog_req_o(prog_req_o), .prog_cnt_o(prog_cnt_o),
    .page_mode_o(page_mode_o), .base_addr_o(base_addr_o), .rd_data_o(rd_data_o),
    .rd_addr_o(rd_addr_o), .next_ptr_o(next_ptr_o), .ptr_upd_o(ptr_upd_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dval(input int b, input int n, input int k);
    return (b * 7 + k * 29 + n * 3 + 5) % 256;
  endfunction

  function automatic int exp_addr(input int b, input int k, input bit pg);
    if (pg) return (b & 8'hF8) | ((b + k) % 8);
    return (b + k) % 256;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic send_addr(input int a, input int exp_ack, input string req);
    addr_load_i = 1'b1; addr_i = 8'(a);
    #1 chk(req, ack_o, exp_ack);
    tick();
    addr_load_i = 1'b0;
  endtask

  task automatic send_byte(input int d, input int exp_ack, input string req);
    byte_vld_i = 1'b1; byte_i = 8'(d);
    #1 chk(req, ack_o, exp_ack);
    tick();
    byte_vld_i = 1'b0;
  endtask

  task automatic pulse_stop();
    stop_i = 1'b1; tick(); stop_i = 1'b0;
  endtask

  task automatic pulse_done();
    done_i = 1'b1; tick(); done_i = 1'b0;
  endtask

  task automatic run_txn(input int b, input int n);
    bit pg;
    pg = (n == 8);
    send_addr(b, 1, "R1 address ack");
    chk("R1 base latched", base_addr_o, b);
    chk("R1 count opens at zero", prog_cnt_o, 0);
    for (int k = 0; k < n; k++) begin
      send_byte(dval(b, n, k), (k < 8) ? 1 : 0, (k < 8) ? "R2 byte ack" : "R3 overflow no ack");
      if (k < 8) chk("R2 count step", prog_cnt_o, k + 1);
    end
    pulse_stop();
    if (n == 0) begin
      chk("R8 pointer pulse", ptr_upd_o, 1);
      chk("R8 no request", prog_req_o, 0);
      chk("R7 pointer at base", next_ptr_o, b);
      tick();
      chk("R8 pulse single", ptr_upd_o, 0);
    end else if (n <= 8) begin
      chk("R4 request", prog_req_o, 1);
      chk("R4 count", prog_cnt_o, n);
      chk("R5 page flag", page_mode_o, pg);
      chk("R8 no pointer pulse", ptr_upd_o, 0);
      chk("R7 next pointer", next_ptr_o, pg ? b : (b + n) % 256);
      for (int k = 0; k < n; k++) begin
        rd_idx_i = 3'(k);
        #1;
        chk("R6 read data", rd_data_o, dval(b, n, k));
        chk("R6 read address", rd_addr_o, exp_addr(b, k, pg));
        tick();
      end
      pulse_done();
      chk("R11 done clears request", prog_req_o, 0);
      chk("R11 done clears count", prog_cnt_o, 0);
    end else begin
      chk("R3 no request after overflow", prog_req_o, 0);
      chk("R3 count dropped", prog_cnt_o, 0);
      chk("R3 no pointer pulse", ptr_upd_o, 0);
    end
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(); tick();
    // R12 reset state
    chk("R12 request low", prog_req_o, 0);
    chk("R12 count zero", prog_cnt_o, 0);
    chk("R12 pointer pulse low", ptr_upd_o, 0);
    chk("R12 no ack idle", ack_o, 0);
    rst_n = 1'b1;
    tick();
    chk("R12 after release", prog_req_o, 0);

    // Sweep every base with every count 0..10
    for (int b = 0; b < 256; b++)
      for (int n = 0; n <= 10; n++)
        run_txn(b, n);

    // R9 repeated START aborts a write
    send_addr(8'h3C, 1, "R1 address ack");
    for (int k = 0; k < 3; k++) send_byte(k + 1, 1, "R2 byte ack");
    start_i = 1'b1; tick(); start_i = 1'b0;
    chk("R9 count after start", prog_cnt_o, 0);
    pulse_stop();
    chk("R9 no request after abort", prog_req_o, 0);
    chk("R9 no pointer pulse", ptr_upd_o, 0);
    send_byte(8'h55, 0, "R9 byte refused after abort");

    // R9 START during a dropped transaction
    send_addr(8'h10, 1, "R1 address ack");
    for (int k = 0; k < 9; k++) send_byte(k, (k < 8) ? 1 : 0, "R3 overflow sequence");
    start_i = 1'b1; tick(); start_i = 1'b0;
    pulse_stop();
    chk("R9 drop then start no request", prog_req_o, 0);

    // R10 busy blocks captures
    busy_i = 1'b1;
    send_addr(8'h20, 0, "R10 address refused while busy");
    busy_i = 1'b0;
    send_addr(8'h20, 1, "R1 address ack");
    send_byte(8'hA1, 1, "R2 byte ack");
    busy_i = 1'b1;
    send_byte(8'hA2, 0, "R10 byte refused while busy");
    chk("R10 count unchanged", prog_cnt_o, 1);
    busy_i = 1'b0;
    send_byte(8'hA3, 1, "R2 byte ack");
    pulse_stop();
    chk("R10 request count", prog_cnt_o, 2);
    rd_idx_i = 3'd1; #1;
    chk("R10 refused byte not stored", rd_data_o, 8'hA3);
    tick();

    // R11 outstanding request blocks everything
    send_addr(8'h40, 0, "R11 address refused while pending");
    send_byte(8'h77, 0, "R11 byte refused while pending");
    start_i = 1'b1; tick(); start_i = 1'b0;
    pulse_stop();
    chk("R11 request holds", prog_req_o, 1);
    chk("R11 count holds", prog_cnt_o, 2);
    chk("R11 base holds", base_addr_o, 8'h20);
    pulse_done();
    chk("R11 cleared by done", prog_req_o, 0);
    send_addr(8'h40, 1, "R1 address ack after done");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule